// File: doc/BRIEF.md
# Designated Vendor Capability Register Block with Byte Write Masks and Lock

This block holds one designated vendor-specific extended capability in a device's configuration space. Software reaches it through a dword-addressed read/write port with four byte-lane enables. Three header dwords are read-only. The first carries the extended capability ID 0x0023, version 1 and a next pointer of zero. The second packs the capability length, revision and vendor ID. The third carries a device capability half-word above the capability ID half-word.

Every byte behind the headers has its own write mask. The control, lock and range fields are writable bit by bit, as the masks allow. A status byte holds event bits that hardware sets and software clears by writing one. A single lock bit can be set once. While it is set, it freezes the control register and both range base registers. A function-level reset input clears the plain configuration fields. Only the cold reset clears the lock bit and the status bits.

Top module: `dvsec_wmask_unit`

## Requirements
- R1: The three header dwords are read-only. The word at base+0x0 reads 0x00010023. The word at base+0x4 reads (length << 20) | (revision << 16) | vendor ID, with the length 36 in bits 31:20 and the revision in bits 19:16. The word at base+0x8 reads {device capability, capability ID}. Writes to these words leave them unchanged.
- R2: The capability occupies 36 bytes from a dword-aligned base of at least 0x100, and its end stays below 0x1000. Reads outside that window return 0, and writes outside it change nothing.
- R3: The control register sits at base+0xC. Its low byte accepts only the bits of mask 0xFD, and its high byte accepts only the bits of mask 0x4F. A byte lane whose enable is low keeps its value.
- R4: The range 1 and range 2 high words (base+0x14 and base+0x1C) are writable in all 32 bits. The range 1 and range 2 low words (base+0x18 and base+0x20) are writable only in bits 31:28, and their other bits read 0.
- R5: Status bits 3:0 sit at base+0xE (bits 19:16 of the control dword). A high stat_set bit sets its status bit. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set and a clear reach the same bit in the same cycle, the set wins. Status bits 7:4 read 0.
- R6: The lock bit is bit 0 at base+0x10. Once it has been written to 1, no later write changes it. cfg_locked shows its value.
- R7: While the lock bit is set, writes to the control register and to all four range words are ignored. The status bits stay clearable while the lock bit is set.
- R8: A low flr_n at a clock edge clears the control register and the range words. It leaves the lock bit and the status bits unchanged. A low cold_rst_n clears every writable bit.
- R9: Reads return the stored value whatever the masks or the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low; clears everything |
| flr_n | input | 1 | Synchronous function-level reset, active low; spares sticky bits |
| cfg_wr | input | 1 | Write strobe for one cycle |
| cfg_addr | input | 10 | Dword address (byte address bits 11:2) |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| stat_set | input | 4 | Hardware events that set status bits 3:0 |
| cfg_locked | output | 1 | Current value of the lock bit |

## Verification
The assertions check the following on every cycle: the lock never falls while the cold reset is high, and the control and range fields stay frozen whenever the lock was set at the previous edge. They also check that a function-level reset clears the plain fields but leaves the status bits and the lock alone, that a hardware event always lands in the status byte and that status bits are never gained without one, and that reads outside the window return zero. The per-byte mask values, the byte-lane enables, the header encoding, the write-one-to-clear data pattern, the set-over-clear collision and the write-once behaviour need chosen data patterns, so only the directed scenarios can show them.

// File: rtl/dvsec_cfg_pkg.sv
package dvsec_cfg_pkg;

  typedef enum logic [1:0] {BK_RO, BK_RW, BK_W1C, BK_ONCE} bkind_e;

  localparam int unsigned CAP_BYTES = 36;
  localparam int unsigned CAP_DW    = CAP_BYTES / 4;
  localparam int unsigned OFS_STAT  = 14;
  localparam int unsigned OFS_LOCK  = 16;

  // write mask of each byte inside the capability
  function automatic logic [7:0] mask_of(int unsigned o);
    case (o)
      12:                  return 8'hFD;
      13:                  return 8'h4F;
      14:                  return 8'h0F;
      16:                  return 8'h01;
      20, 21, 22, 23:      return 8'hFF;
      27:                  return 8'hF0;
      28, 29, 30, 31:      return 8'hFF;
      35:                  return 8'hF0;
      default:             return 8'h00;
    endcase
  endfunction

  function automatic bit lockable_of(int unsigned o);
    return (o == 12) || (o == 13) || (o >= 20 && o <= 23) || (o == 27) ||
           (o >= 28 && o <= 31) || (o == 35);
  endfunction

  function automatic bkind_e kind_of(int unsigned o);
    if (o == OFS_STAT) return BK_W1C;
    if (o == OFS_LOCK) return BK_ONCE;
    if (mask_of(o) != 8'h00) return BK_RW;
    return BK_RO;
  endfunction

  function automatic logic [31:0] hdr1_word(logic [11:0] len, logic [3:0] rev,
                                            logic [15:0] vid);
    return {len, rev, vid};
  endfunction

  function automatic bit placement_ok(int unsigned base, int unsigned len);
    return (base >= 256) && ((base + len) < 4096) && ((base % 4) == 0);
  endfunction

endpackage

// File: rtl/dvsec_addr_dec.sv
module dvsec_addr_dec #(
  parameter int unsigned BASE = 256,
  parameter int unsigned NDW  = 9,
  localparam int unsigned IDXW = $clog2(NDW)
) (
  input  logic [11:2]     addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  localparam logic [9:0] BASE_DW = 10'(BASE / 4);
  localparam logic [9:0] END_DW  = 10'(BASE / 4 + NDW);

  assign hit = (addr >= BASE_DW) && (addr < END_DW);
  assign idx = IDXW'(addr - BASE_DW);
endmodule

// File: rtl/dvsec_byte_cell.sv
module dvsec_byte_cell
  import dvsec_cfg_pkg::*;
#(
  parameter bkind_e     KIND     = BK_RW,
  parameter logic [7:0] MASK     = 8'hFF,
  parameter bit         LOCKABLE = 1'b0
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       flr_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       locked,
  input  logic [7:0] set_bits,
  output logic [7:0] q
);
  localparam bit STICKY = (KIND == BK_W1C) || (KIND == BK_ONCE);

  logic [7:0] clr_bits;
  assign clr_bits = we ? (wdata & MASK) : 8'h00;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      q <= 8'h00;
    end else if (!flr_n && !STICKY) begin
      q <= 8'h00;
    end else begin
      case (KIND)
        BK_W1C:  q <= (q & ~clr_bits) | (set_bits & MASK);
        BK_ONCE: q <= q | clr_bits;
        default: if (we && !(LOCKABLE && locked)) q <= (q & ~MASK) | (wdata & MASK);
      endcase
    end
  end
endmodule

// File: rtl/dvsec_wmask_unit.sv
module dvsec_wmask_unit
  import dvsec_cfg_pkg::*;
#(
  parameter int unsigned CAP_BASE  = 256,
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [3:0]  CAP_REV   = 4'h1,
  parameter logic [15:0] CAP_ID    = 16'h0000,
  parameter logic [15:0] DEV_CAP   = 16'h0014
) (
  input  logic        clk,
  input  logic        cold_rst_n,
  input  logic        flr_n,
  input  logic        cfg_wr,
  input  logic [11:2] cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [3:0]  stat_set,
  output logic        cfg_locked
);
  localparam int unsigned IDXW = $clog2(CAP_DW);
  localparam logic [31:0] HDR0 = 32'h0001_0023;
  localparam logic [31:0] HDR1 = hdr1_word(12'(CAP_BYTES), CAP_REV, VENDOR_ID);
  localparam logic [31:0] HDR2 = {DEV_CAP, CAP_ID};

  if (!placement_ok(CAP_BASE, CAP_BYTES)) begin : g_bad_place
    $error("capability window out of the extended configuration range");
  end

  function automatic logic [7:0] ro_byte(int unsigned o);
    logic [31:0] w;
    w = (o < 4) ? HDR0 : (o < 8) ? HDR1 : (o < 12) ? HDR2 : 32'h0;
    return w[8*(o%4) +: 8];
  endfunction

  logic            win_hit;
  logic [IDXW-1:0] dw_idx;
  logic [7:0]      byte_q [CAP_BYTES];

  dvsec_addr_dec #(.BASE(CAP_BASE), .NDW(CAP_DW)) u_dec (
    .addr (cfg_addr),
    .hit  (win_hit),
    .idx  (dw_idx)
  );

  for (genvar b = 0; b < CAP_BYTES; b++) begin : g_byte
    localparam bkind_e K = kind_of(b);
    if (K == BK_RO) begin : g_ro
      assign byte_q[b] = ro_byte(b);
    end else begin : g_cell
      logic       we_b;
      logic [7:0] set_v;
      assign we_b  = cfg_wr && win_hit && (dw_idx == IDXW'(b / 4)) && cfg_be[b % 4];
      assign set_v = (b == OFS_STAT) ? {4'h0, stat_set} : 8'h00;
      dvsec_byte_cell #(
        .KIND     (K),
        .MASK     (mask_of(b)),
        .LOCKABLE (lockable_of(b))
      ) u_cell (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .flr_n      (flr_n),
        .we         (we_b),
        .wdata      (cfg_wdata[8*(b%4) +: 8]),
        .locked     (cfg_locked),
        .set_bits   (set_v),
        .q          (byte_q[b])
      );
    end
  end

  always_comb begin
    cfg_rdata = 32'h0;
    if (win_hit) begin
      for (int j = 0; j < 4; j++) begin
        cfg_rdata[8*j +: 8] = byte_q[{dw_idx, 2'(j)}];
      end
    end
  end

  // named views for the checker
  logic [15:0] ctrl_q;
  logic [7:0]  stat_q;
  logic [79:0] rng_q;
  assign ctrl_q     = {byte_q[13], byte_q[12]};
  assign stat_q     = byte_q[OFS_STAT];
  assign cfg_locked = byte_q[OFS_LOCK][0];
  assign rng_q      = {byte_q[23], byte_q[22], byte_q[21], byte_q[20], byte_q[27],
                       byte_q[31], byte_q[30], byte_q[29], byte_q[28], byte_q[35]};
endmodule

// File: rtl/dvsec_wmask_chk.sv
module dvsec_wmask_chk (
  input logic        clk,
  input logic        cold_rst_n,
  input logic        flr_n,
  input logic        cfg_wr,
  input logic [3:0]  stat_set,
  input logic [31:0] cfg_rdata,
  input logic        cfg_locked,
  input logic        win_hit,
  input logic [15:0] ctrl_q,
  input logic [7:0]  stat_q,
  input logic [79:0] rng_q
);
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!cold_rst_n)
    cfg_locked |=> cfg_locked);

  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (cfg_locked && flr_n) |=> ($stable(ctrl_q) && $stable(rng_q)));

  a_r8_flr_clears: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !flr_n |=> (ctrl_q == 16'h0 && rng_q == 80'h0));

  a_r8_flr_spares_sticky: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!flr_n && !cfg_wr && stat_set == 4'h0) |=> ($stable(stat_q) && $stable(cfg_locked)));

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (stat_set != 4'h0) |=> ((stat_q[3:0] & $past(stat_set)) == $past(stat_set)));

  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (stat_set == 4'h0) |=> ((stat_q & ~$past(stat_q)) == 8'h0));

  a_r2_outside_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !win_hit |-> (cfg_rdata == 32'h0));
endmodule

bind dvsec_wmask_unit dvsec_wmask_chk u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .flr_n      (flr_n),
  .cfg_wr     (cfg_wr),
  .stat_set   (stat_set),
  .cfg_rdata  (cfg_rdata),
  .cfg_locked (cfg_locked),
  .win_hit    (win_hit),
  .ctrl_q     (ctrl_q),
  .stat_q     (stat_q),
  .rng_q      (rng_q)
);

// File: tb/dvsec_wmask_unit_tb_top.sv
module dvsec_wmask_unit_tb_top;
  logic        clk = 1'b0;
  logic        cold_rst_n, flr_n, cfg_wr;
  logic [11:2] cfg_addr;
  logic [3:0]  cfg_be, stat_set;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_locked;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  localparam logic [11:0] A_H0 = 12'h100, A_H1 = 12'h104, A_H2 = 12'h108,
                          A_CTL = 12'h10C, A_LCK = 12'h110, A_R1H = 12'h114,
                          A_R1L = 12'h118, A_R2H = 12'h11C, A_R2L = 12'h120;

  always #2 clk = ~clk;

  dvsec_wmask_unit dut_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .flr_n(flr_n), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stat_set(stat_set), .cfg_locked(cfg_locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a[11:2]; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a[11:2];
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic pulse_stat(input logic [3:0] v);
    @(negedge clk); stat_set = v;
    @(negedge clk); stat_set = 4'h0;
  endtask

  task automatic pulse_flr();
    @(negedge clk); flr_n = 1'b0;
    @(negedge clk); flr_n = 1'b1;
  endtask

  task automatic t_reset();
    rd(A_H0, 32'h0001_0023, "R1 hdr0");
    rd(A_H1, 32'h0241_ABCD, "R1 hdr1");
    rd(A_H2, 32'h0014_0000, "R1 hdr2");
    rd(A_CTL, 32'h0, "R8 ctrl after cold reset");
    rd(A_LCK, 32'h0, "R8 lock after cold reset");
    chk("R6 cfg_locked at reset", {31'h0, cfg_locked}, 32'h0);
    wr(A_H1, 4'hF, 32'hFFFF_FFFF);
    rd(A_H1, 32'h0241_ABCD, "R1 hdr1 ignores write");
  endtask

  task automatic t_ctrl_mask();
    wr(A_CTL, 4'hF, 32'hFFFF_FFFF);
    rd(A_CTL, 32'h0000_4FFD, "R3 ctrl masks");
    wr(A_CTL, 4'b0001, 32'h0);
    rd(A_CTL, 32'h0000_4F00, "R3 lane0 only");
    wr(A_CTL, 4'b0010, 32'h0000_0F00);
    rd(A_CTL, 32'h0000_0F00, "R3 lane1 only");
  endtask

  task automatic t_range();
    wr(A_R1H, 4'hF, 32'h1234_5678);
    rd(A_R1H, 32'h1234_5678, "R4 r1 high");
    wr(A_R1L, 4'hF, 32'hFFFF_FFFF);
    rd(A_R1L, 32'hF000_0000, "R4 r1 low");
    wr(A_R2H, 4'b0110, 32'hAABB_CCDD);
    rd(A_R2H, 32'h00BB_CC00, "R4 r2 high lanes");
    wr(A_R2L, 4'hF, 32'h5A5A_5A5A);
    rd(A_R2L, 32'h5000_0000, "R4 r2 low");
  endtask

  task automatic t_status();
    pulse_stat(4'b1010);
    rd(A_CTL, 32'h000A_0F00, "R5 set by event");
    wr(A_CTL, 4'b0100, 32'h0002_0000);
    rd(A_CTL, 32'h0008_0F00, "R5 write one clears");
    wr(A_CTL, 4'b0100, 32'h0);
    rd(A_CTL, 32'h0008_0F00, "R5 write zero no effect");
    wr(A_CTL, 4'b0100, 32'h00F8_0000);
    rd(A_CTL, 32'h0000_0F00, "R5 upper bits read zero");
    @(negedge clk);
    stat_set = 4'b0001; cfg_addr = A_CTL[11:2]; cfg_be = 4'b0100;
    cfg_wdata = 32'h0001_0000; cfg_wr = 1'b1;
    @(negedge clk);
    stat_set = 4'h0; cfg_wr = 1'b0;
    rd(A_CTL, 32'h0001_0F00, "R5 set wins over clear");
    wr(A_CTL, 4'b0100, 32'h0001_0000);
    pulse_stat(4'b0100);
    rd(A_CTL, 32'h0004_0F00, "R5 set again");
  endtask

  task automatic t_flr();
    pulse_flr();
    rd(A_CTL, 32'h0004_0000, "R8 flr clears ctrl keeps status");
    rd(A_R1H, 32'h0, "R8 flr clears range");
    rd(A_R1L, 32'h0, "R8 flr clears range low");
  endtask

  task automatic t_lock();
    wr(A_CTL, 4'hF, 32'h0000_00FD);
    wr(A_R1H, 4'hF, 32'h1111_2222);
    wr(A_LCK, 4'hF, 32'hFFFF_FFFF);
    rd(A_LCK, 32'h0000_0001, "R6 lock set");
    chk("R6 cfg_locked", {31'h0, cfg_locked}, 32'h1);
    wr(A_LCK, 4'hF, 32'h0);
    rd(A_LCK, 32'h0000_0001, "R6 lock write once");
    wr(A_CTL, 4'hF, 32'h0000_4F00);
    rd(A_CTL, 32'h0004_00FD, "R7 ctrl blocked");
    wr(A_R1H, 4'hF, 32'h0);
    rd(A_R1H, 32'h1111_2222, "R9 R7 range high blocked");
    wr(A_R2L, 4'hF, 32'hFFFF_FFFF);
    rd(A_R2L, 32'h0, "R7 range low blocked");
    wr(A_CTL, 4'b0100, 32'h0004_0000);
    rd(A_CTL, 32'h0000_00FD, "R7 status clears while locked");
  endtask

  task automatic t_flr_locked();
    pulse_stat(4'b0011);
    pulse_flr();
    rd(A_CTL, 32'h0003_0000, "R8 flr while locked");
    rd(A_LCK, 32'h0000_0001, "R8 lock survives flr");
    rd(A_R1H, 32'h0, "R8 range cleared while locked");
    wr(A_CTL, 4'hF, 32'h0000_00FD);
    rd(A_CTL, 32'h0003_0000, "R7 still blocked after flr");
  endtask

  task automatic t_cold();
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    rd(A_LCK, 32'h0, "R8 cold clears lock");
    rd(A_CTL, 32'h0, "R8 cold clears status");
    chk("R8 cfg_locked after cold", {31'h0, cfg_locked}, 32'h0);
  endtask

  task automatic t_window();
    wr(A_R2L, 4'hF, 32'hA000_0000);
    wr(12'h124, 4'hF, 32'hFFFF_FFFF);
    wr(12'h0FC, 4'hF, 32'hFFFF_FFFF);
    rd(12'h124, 32'h0, "R2 read past end");
    rd(12'h0FC, 32'h0, "R2 read below base");
    rd(A_R2L, 32'hA000_0000, "R2 neighbour untouched");
    rd(A_H0, 32'h0001_0023, "R2 header untouched");
    rd(A_CTL, 32'h0, "R2 ctrl untouched");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    cold_rst_n = 1'b0; flr_n = 1'b1; cfg_wr = 1'b0; cfg_addr = '0;
    cfg_be = 4'h0; cfg_wdata = 32'h0; stat_set = 4'h0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_range();
    t_status();
    t_flr();
    t_lock();
    t_flr_locked();
    t_cold();
    t_window();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      summary();
      $finish;
    end
  end
endmodule